// File: doc/BRIEF.md
# Dual-Channel ADC Output Formatter

This block sits behind a two-channel sampling converter and turns its paired raw 10-bit codes into the words that leave the chip. Both channels are sampled at the same instant. A delay model stands in for the conversion pipeline and gives each operating mode its fixed latency. Two configuration inputs pick the mode. In the two dual-bus modes, channel A and channel B leave side by side on two buses that update together. In the two single-bus modes, the samples are interleaved on bus A in the order A, B, A, B, with channel B one cycle behind channel A.

A latch clock and its complement go with the data so that a receiver can capture it. In the single-bus modes, the latch clock level tells the receiver which channel is on the bus. An output-coding input picks between offset binary and two's complement for both channels. An active-low output enable and a standby input switch every output off. High impedance is modelled with a per-bus enable output, and a disabled bus is driven to zero.

Top module: `adc_dual_fmt`

## Requirements
- R1: While reset is high, both buses and the latch clock are zero, and no sample is in flight when reset is released.
- R2: Channels are captured on the first clock edge after reset is released and on every second edge after that. The exception is the mode with mode_sel=1 and single_bus=0, which captures on every edge.
- R3: With mode_sel=0 and single_bus=0, a pair captured at edge k appears on da and db together just after edge k+8 and is held for two cycles.
- R4: With mode_sel=1 and single_bus=0, a pair captured at edge k appears on da and db together just after edge k+4, and a new pair follows every cycle.
- R5: With single_bus=1, for either value of mode_sel, the channel A word of a pair captured at edge k appears on da just after edge k+8. The channel B word of the same pair follows just after edge k+9.
- R6: With single_bus=1, db_en is low and db is zero.
- R7: lck is 1 while a channel A word is on da in single-bus modes and 0 while a channel B word is on it. In mode 0/0, lck is 1 for the first cycle of each pair and 0 for the second. In mode 1/0, lck toggles every cycle. lck_n is always the complement of lck while the outputs are enabled.
- R8: With twos_en=0, the output equals the raw code: mid-scale 0x200, top 0x3FF, bottom 0x000. With twos_en=1, bit 9 of both channels is inverted, so 0x200 leaves as 0x000, 0x3FF as 0x1FF and 0x000 as 0x200.
- R9: With oe_n=1, da_en, db_en and lck_en are low, and da, db, lck and lck_n are zero. The held words reappear when oe_n returns to 0.
- R10: With stby=1, every output is disabled and zero, the same as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_a | input | 10 | Raw code of channel A |
| raw_b | input | 10 | Raw code of channel B |
| mode_sel | input | 1 | Clock-rate mode select |
| single_bus | input | 1 | 1 selects interleaved single-bus output |
| twos_en | input | 1 | 1 selects two's complement coding |
| oe_n | input | 1 | Output enable, active low |
| stby | input | 1 | Standby; disables all outputs |
| da | output | 10 | Primary data bus |
| da_en | output | 1 | Drive enable of da |
| db | output | 10 | Secondary data bus |
| db_en | output | 1 | Drive enable of db |
| lck | output | 1 | Output latch clock |
| lck_n | output | 1 | Complement of the latch clock |
| lck_en | output | 1 | Drive enable of both latch clocks |

## Verification
The bench builds the block with its default latencies of 8, 4 and 8 cycles. At these values the 9-cycle channel B path of the single-bus modes and the 4-cycle fast dual path both fit inside one short directed window after each reset. Every vector captures one pair on the first edge and a different pair on a later edge. This makes both the exact latency and the capture cadence visible in each of the four modes. The two's-complement boundary codes are part of the vector table.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
    parameter int CODE_W = 10;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t a;
        code_t b;
        logic  vld;
    } tap_t;

    typedef enum logic [1:0] {
        MD_DUAL_SLOW = 2'd0,
        MD_DUAL_FAST = 2'd1,
        MD_SINGLE    = 2'd2
    } omode_e;

    function automatic omode_e decode_mode(logic m, logic s);
        if (s) return MD_SINGLE;
        return m ? MD_DUAL_FAST : MD_DUAL_SLOW;
    endfunction

    function automatic code_t code_fmt(code_t c, logic twos);
        code_t r;
        r = c;
        r[CODE_W-1] = c[CODE_W-1] ^ twos;
        return r;
    endfunction
endpackage

// File: rtl/adc_fmt_phase.sv
module adc_fmt_phase (
    input  logic clk,
    input  logic rst,
    input  logic full_rate,
    output logic smp
);
    logic ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ~ph_q;
    end

    assign smp = ~rst & (full_rate | ~ph_q);
endmodule

// File: rtl/adc_fmt_delay.sv
module adc_fmt_delay
    import adc_fmt_pkg::*;
#(
    parameter int DEPTH    = 9,
    parameter int LAT_SLOW = 8,
    parameter int LAT_FAST = 4,
    parameter int LAT_SGL  = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  smp,
    input  code_t raw_a,
    input  code_t raw_b,
    output tap_t  tap_slow,
    output tap_t  tap_fast,
    output tap_t  tap_sgl_a,
    output tap_t  tap_sgl_b
);
    tap_t taps [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) taps[0] <= '0;
        else     taps[0] <= '{a: raw_a, b: raw_b, vld: smp};
    end

    for (genvar j = 1; j < DEPTH; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) taps[j] <= '0;
            else     taps[j] <= taps[j-1];
        end
    end

    assign tap_slow  = taps[LAT_SLOW-1];
    assign tap_fast  = taps[LAT_FAST-1];
    assign tap_sgl_a = taps[LAT_SGL-1];
    assign tap_sgl_b = taps[LAT_SGL];
endmodule

// File: rtl/adc_fmt_outsel.sv
module adc_fmt_outsel
    import adc_fmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  omode_e omode,
    input  logic   twos_en,
    input  tap_t   tap_slow,
    input  tap_t   tap_fast,
    input  tap_t   tap_sgl_a,
    input  tap_t   tap_sgl_b,
    output code_t  bus_a_q,
    output code_t  bus_b_q,
    output logic   lck_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_a_q <= '0;
            bus_b_q <= '0;
            lck_q   <= 1'b0;
        end else begin
            case (omode)
                MD_DUAL_SLOW: begin
                    if (tap_slow.vld) begin
                        bus_a_q <= code_fmt(tap_slow.a, twos_en);
                        bus_b_q <= code_fmt(tap_slow.b, twos_en);
                    end
                    lck_q <= tap_slow.vld;
                end
                MD_DUAL_FAST: begin
                    if (tap_fast.vld) begin
                        bus_a_q <= code_fmt(tap_fast.a, twos_en);
                        bus_b_q <= code_fmt(tap_fast.b, twos_en);
                    end
                    lck_q <= ~lck_q;
                end
                MD_SINGLE: begin
                    if (tap_sgl_a.vld) begin
                        bus_a_q <= code_fmt(tap_sgl_a.a, twos_en);
                        lck_q   <= 1'b1;
                    end else if (tap_sgl_b.vld) begin
                        bus_a_q <= code_fmt(tap_sgl_b.b, twos_en);
                        lck_q   <= 1'b0;
                    end
                end
                default: lck_q <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/adc_dual_fmt.sv
module adc_dual_fmt
    import adc_fmt_pkg::*;
#(
    parameter int LAT_SLOW = 8,
    parameter int LAT_FAST = 4,
    parameter int LAT_SGL  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] raw_a,
    input  logic [CODE_W-1:0] raw_b,
    input  logic              mode_sel,
    input  logic              single_bus,
    input  logic              twos_en,
    input  logic              oe_n,
    input  logic              stby,
    output logic [CODE_W-1:0] da,
    output logic              da_en,
    output logic [CODE_W-1:0] db,
    output logic              db_en,
    output logic              lck,
    output logic              lck_n,
    output logic              lck_en
);
    localparam int DEPTH = (LAT_SLOW > LAT_SGL + 1) ? LAT_SLOW : LAT_SGL + 1;

    omode_e omode;
    logic   smp;
    tap_t   tap_slow, tap_fast, tap_sgl_a, tap_sgl_b;
    code_t  bus_a_q, bus_b_q;
    logic   lck_q;
    logic   drive;

    assign omode = decode_mode(mode_sel, single_bus);

    adc_fmt_phase u_phase (
        .clk       (clk),
        .rst       (rst),
        .full_rate (omode == MD_DUAL_FAST),
        .smp       (smp)
    );

    adc_fmt_delay #(
        .DEPTH    (DEPTH),
        .LAT_SLOW (LAT_SLOW),
        .LAT_FAST (LAT_FAST),
        .LAT_SGL  (LAT_SGL)
    ) u_delay (
        .clk       (clk),
        .rst       (rst),
        .smp       (smp),
        .raw_a     (raw_a),
        .raw_b     (raw_b),
        .tap_slow  (tap_slow),
        .tap_fast  (tap_fast),
        .tap_sgl_a (tap_sgl_a),
        .tap_sgl_b (tap_sgl_b)
    );

    adc_fmt_outsel u_outsel (
        .clk       (clk),
        .rst       (rst),
        .omode     (omode),
        .twos_en   (twos_en),
        .tap_slow  (tap_slow),
        .tap_fast  (tap_fast),
        .tap_sgl_a (tap_sgl_a),
        .tap_sgl_b (tap_sgl_b),
        .bus_a_q   (bus_a_q),
        .bus_b_q   (bus_b_q),
        .lck_q     (lck_q)
    );

    assign drive  = ~oe_n & ~stby;
    assign da_en  = drive;
    assign db_en  = drive & ~single_bus;
    assign lck_en = drive;
    assign da     = da_en ? bus_a_q : '0;
    assign db     = db_en ? bus_b_q : '0;
    assign lck    = drive & lck_q;
    assign lck_n  = drive & ~lck_q;
endmodule

// File: rtl/adc_dual_fmt_chk.sv
module adc_dual_fmt_chk
    import adc_fmt_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  mode_sel,
    input logic  single_bus,
    input logic  twos_en,
    input logic  oe_n,
    input logic  stby,
    input code_t raw_a,
    input code_t da,
    input logic  da_en,
    input code_t db,
    input logic  db_en,
    input logic  lck,
    input logic  lck_n,
    input logic  lck_en,
    input code_t bus_a_q,
    input logic  lck_q
);
    logic [3:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 4'hF) cyc <= cyc + 4'd1;
    end

    // R4: fast dual bus carries the code captured five edges earlier
    p_lat_fast_r4: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 4'd5 && mode_sel && !single_bus) |-> bus_a_q == code_fmt($past(raw_a, 5), twos_en));

    // R3: a change of the slow dual bus always coincides with a high latch clock
    p_dual_together_r3: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 4'd2 && !mode_sel && !single_bus && !$stable(bus_a_q)) |-> lck_q);

    // R7: outside the fast dual mode the latch clock is never high two cycles running
    p_lck_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (!(mode_sel && !single_bus) && lck_q) |=> !lck_q);

    // R9, R10: disabled outputs stay quiet
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (oe_n || stby) |-> (!da_en && !db_en && !lck_en && da == '0 && db == '0 && !lck && !lck_n));

    // R6: second bus is off in single-bus modes
    p_single_b_off_r6: assert property (@(posedge clk) disable iff (rst)
        single_bus |-> (!db_en && db == '0));
endmodule

bind adc_dual_fmt adc_dual_fmt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .single_bus (single_bus),
    .twos_en    (twos_en),
    .oe_n       (oe_n),
    .stby       (stby),
    .raw_a      (raw_a),
    .da         (da),
    .da_en      (da_en),
    .db         (db),
    .db_en      (db_en),
    .lck        (lck),
    .lck_n      (lck_n),
    .lck_en     (lck_en),
    .bus_a_q    (bus_a_q),
    .lck_q      (lck_q)
);

// File: tb/adc_dual_fmt_tb.sv
module adc_dual_fmt_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] raw_a = '0, raw_b = '0;
    logic       mode_sel = 1'b0, single_bus = 1'b0, twos_en = 1'b0;
    logic       oe_n = 1'b0, stby = 1'b0;
    logic [9:0] da, db;
    logic       da_en, db_en, lck, lck_n, lck_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    adc_dual_fmt u_dut (
        .clk(clk), .rst(rst), .raw_a(raw_a), .raw_b(raw_b),
        .mode_sel(mode_sel), .single_bus(single_bus), .twos_en(twos_en),
        .oe_n(oe_n), .stby(stby), .da(da), .da_en(da_en), .db(db),
        .db_en(db_en), .lck(lck), .lck_n(lck_n), .lck_en(lck_en)
    );

    // {mode, single, twos, first A, first B, later A, later B}
    localparam int NV = 7;
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 10'h155, 10'h2AA, 10'h001, 10'h3FE},
        {1'b0, 1'b0, 1'b1, 10'h200, 10'h3FF, 10'h000, 10'h1FF},
        {1'b1, 1'b0, 1'b0, 10'h0F0, 10'h30F, 10'h123, 10'h321},
        {1'b1, 1'b0, 1'b1, 10'h000, 10'h3FF, 10'h200, 10'h1FF},
        {1'b0, 1'b1, 1'b0, 10'h111, 10'h222, 10'h333, 10'h044},
        {1'b1, 1'b1, 1'b1, 10'h3FF, 10'h000, 10'h080, 10'h280},
        {1'b0, 1'b0, 1'b0, 10'h2F0, 10'h0F1, 10'h1A5, 10'h25A}
    };

    // R8: two's complement inverts bit 9 only
    function automatic logic [9:0] cod(logic [9:0] v, logic t);
        return t ? {~v[9], v[8:0]} : v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(logic [42:0] v);
        logic m, s, t;
        logic [9:0] va, vb, xa, xb;
        {m, s, t, va, vb, xa, xb} = v;
        @(negedge clk);
        rst = 1'b1; mode_sel = m; single_bus = s; twos_en = t;
        raw_a = va; raw_b = vb;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 da in reset", da, 0);
        chk("R1 lck in reset", lck, 0);
        rst = 1'b0;
        for (int n = 1; n <= 12; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == 1) begin raw_a = xa; raw_b = xb; end
            if (!s && !m) begin
                if (n == 8) begin chk("R3 early", da, 0); chk("R1 nothing in flight", lck, 0); end
                if (n == 9) begin
                    chk("R3 da", da, cod(va, t)); chk("R3 db", db, cod(vb, t));
                    chk("R7 lck first", lck, 1); chk("R8 coding", db, cod(vb, t));
                end
                if (n == 10) begin chk("R3 hold", da, cod(va, t)); chk("R7 lck second", lck, 0); end
                if (n == 11) begin chk("R2 next pair", da, cod(xa, t)); chk("R3 next db", db, cod(xb, t)); end
            end else if (!s && m) begin
                if (n == 4) chk("R4 early", da, 0);
                if (n == 5) begin
                    chk("R4 da", da, cod(va, t)); chk("R4 db", db, cod(vb, t));
                    chk("R7 lck toggle", lck, 1); chk("R7 lck_n", lck_n, 0);
                end
                if (n == 6) begin
                    chk("R2 every edge da", da, cod(xa, t)); chk("R2 every edge db", db, cod(xb, t));
                    chk("R7 lck toggle back", lck, 0);
                end
            end else begin
                if (n == 8) begin chk("R5 early", da, 0); chk("R7 idle", lck, 0); end
                if (n == 9) begin chk("R5 A word", da, cod(va, t)); chk("R7 A marker", lck, 1); end
                if (n == 10) begin
                    chk("R5 B word", da, cod(vb, t)); chk("R7 B marker", lck, 0);
                    chk("R7 lck_n", lck_n, 1);
                    chk("R6 db_en", db_en, 0); chk("R6 db", db, 0);
                end
                if (n == 11) chk("R5 next A", da, cod(xa, t));
                if (n == 12) chk("R5 next B", da, cod(xb, t));
            end
        end
    endtask

    initial begin
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // last vector leaves slow dual mode holding the later pair
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        chk("R9 da_en", da_en, 0); chk("R9 db_en", db_en, 0); chk("R9 lck_en", lck_en, 0);
        chk("R9 da", da, 0); chk("R9 db", db, 0);
        chk("R9 lck pair", {lck, lck_n}, 0);
        @(negedge clk);
        oe_n = 1'b0;
        #1;
        chk("R9 restored da", da, 10'h1A5); chk("R9 restored db", db, 10'h25A);
        @(negedge clk);
        stby = 1'b1;
        #1;
        chk("R10 da_en", da_en, 0); chk("R10 db", db, 0); chk("R10 lck_en", lck_en, 0);
        chk("R10 lck pair", {lck, lck_n}, 0);
        @(negedge clk);
        stby = 1'b0;
        #1;
        chk("R10 restored da", da, 10'h1A5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule